// File: doc/BRIEF.md
# Chainable Synchronous Binary Counter Stage

This block is an up-counter with a parameterised width (4 bits by default). Clear, preset and increment all take effect on the rising clock edge. A synchronous clear has the highest priority, a synchronous preset comes next, and counting happens only when two separate enables are both high. The stage also drives a terminal-carry output that is decoded combinationally. That output is gated by only one of the two enables, the chaining enable, so a wider counter can be built from identical stages.

To build a wider counter, connect each stage's carry output to the chaining enable of the next, more significant stage. Drive the other enable, the shared enable, in parallel to all stages. The stages then count as one binary counter, and a carry ripples forward only through the combinational gate in each stage.

A shorter count cycle needs no extra logic inside the block. Decode the last wanted state from the outputs and drive the active-low clear with that decode. Because the clear acts at the following edge, decoding state N-1 gives a divide-by-N sequence.

Top module: `casc_counter`

## Requirements
- R1: The `count` output changes only at a rising edge of `clk`. A change on any control or data input between edges leaves `count` unchanged until the next edge.
- R2: When `clear_n` is 0 at an edge, `count` becomes 0, whatever `load_n`, `cnt_en` and `carry_in` are.
- R3: When `clear_n` is 1 and `load_n` is 0 at an edge, `count` takes `load_val`, whatever `cnt_en` and `carry_in` are.
- R4: When `clear_n`, `load_n`, `cnt_en` and `carry_in` are all 1 at an edge, `count` increments by one modulo 2^WIDTH, so all ones wraps to 0.
- R5: When `clear_n` and `load_n` are 1 and at least one of `cnt_en` or `carry_in` is 0 at an edge, `count` keeps its value.
- R6: `carry_out` is 1 exactly when `carry_in` is 1 and `count` is all ones. It follows `carry_in` combinationally and does not depend on `cnt_en`.
- R7: A clear, then a preset of 12, then six enabled edges gives 13, 14, 15, 0, 1, 2. `carry_out` is high only while the count is 15. With the enable low afterwards, the count holds at 2.
- R8: Driving `clear_n` low from a decode of state N-1 makes the stage cycle through 0 to N-1. Decoding 4 gives modulo 5, and decoding 10 gives modulo 11.
- R9: Two stages, with the upper `carry_in` fed from the lower `carry_out` and `cnt_en`, `clear_n` and `load_n` shared, behave as one 8-bit counter under any sequence of controls and preset data.
- R10: The width is the parameter WIDTH, and the terminal value is all ones at that width. For example, with WIDTH 3 the carry asserts at 7 and the count wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset from `load_val`, active low |
| cnt_en | input | 1 | Shared count enable, active high |
| carry_in | input | 1 | Chaining count enable, also gates `carry_out` |
| load_val | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal carry to the next stage |

## Verification
Every start value is combined with all sixteen settings of the four controls, with the preset data set to the complement of the start value. This separates clear, preset, increment and hold, and it shows whether the priority order is right. For each pair the carry output is checked before the edge and the count is checked both between edges and after the edge. This separates the combinational carry from the registered count. The fixed preset-and-count sequence and two decoded-clear rings test the wrap and the short cycles. A long pseudo-random control stream on a two-stage chain, compared with an 8-bit arithmetic model, tests carry propagation between stages, including presets and clears in the middle of a carry.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_in,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] TERM = '1;

  logic advance;
  assign advance = cnt_en & carry_in;

  always_ff @(posedge clk) begin
    if (!clear_n)     count <= '0;
    else if (!load_n) count <= load_val;
    else if (advance) count <= count + 1'b1;
  end

  assign carry_out = carry_in & (count == TERM);
endmodule

module casc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             carry_in,
  input logic [WIDTH-1:0] load_val,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  logic seen = 1'b0;
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    seen  <= seen | ~clear_n;
    armed <= seen;
  end

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> count == '0);
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!armed)
    clear_n && !load_n |=> count == $past(load_val));
  a_r4_increment: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && cnt_en && carry_in |=> (count - $past(count)) == ONE);
  a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
    clear_n && load_n && !(cnt_en && carry_in) |=> $stable(count));
  a_r6_gated_by_chain: assert property (@(posedge clk) disable iff (!armed)
    !carry_in |-> !carry_out);
  a_r6_wrap_after_carry: assert property (@(posedge clk) disable iff (!armed)
    carry_out && clear_n && load_n && cnt_en |=> count == '0);
endmodule

bind casc_counter casc_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
  .carry_in(carry_in), .load_val(load_val), .count(count), .carry_out(carry_out)
);

// File: tb/casc_counter_tb.sv
module casc_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // single stage
  logic       clear_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_in = 1'b0;
  logic [3:0] load_val = '0;
  logic [3:0] count;
  logic       carry_out;
  casc_counter #(.WIDTH(4)) dut_i (.clk, .clear_n, .load_n, .cnt_en, .carry_in,
    .load_val, .count, .carry_out);

  // two chained stages
  logic       c_clear_n = 1'b0, c_load_n = 1'b1, c_en = 1'b0, c_chain = 1'b0;
  logic [7:0] c_val = '0;
  logic [3:0] lo_q, hi_q;
  logic       lo_c, hi_c;
  casc_counter #(.WIDTH(4)) lo_i (.clk, .clear_n(c_clear_n), .load_n(c_load_n),
    .cnt_en(c_en), .carry_in(c_chain), .load_val(c_val[3:0]), .count(lo_q), .carry_out(lo_c));
  casc_counter #(.WIDTH(4)) hi_i (.clk, .clear_n(c_clear_n), .load_n(c_load_n),
    .cnt_en(c_en), .carry_in(lo_c), .load_val(c_val[7:4]), .count(hi_q), .carry_out(hi_c));

  // decoded-clear rings and a 3-bit stage
  logic       mod_go = 1'b0;
  logic [3:0] m5_q, m11_q;
  logic [2:0] w3_q;
  logic       m5_c, m11_c, w3_c;
  logic       m5_clr, m11_clr;
  assign m5_clr  = mod_go & (m5_q != 4'd4);
  assign m11_clr = mod_go & (m11_q != 4'd10);
  casc_counter #(.WIDTH(4)) m5_i (.clk, .clear_n(m5_clr), .load_n(1'b1), .cnt_en(1'b1),
    .carry_in(1'b1), .load_val(4'd0), .count(m5_q), .carry_out(m5_c));
  casc_counter #(.WIDTH(4)) m11_i (.clk, .clear_n(m11_clr), .load_n(1'b1), .cnt_en(1'b1),
    .carry_in(1'b1), .load_val(4'd0), .count(m11_q), .carry_out(m11_c));
  casc_counter #(.WIDTH(3)) w3_i (.clk, .clear_n(mod_go), .load_n(1'b1), .cnt_en(1'b1),
    .carry_in(1'b1), .load_val(3'd0), .count(w3_q), .carry_out(w3_c));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    clear_n = 1'b0;
    tick();
    tick();
    chk("R2 reset count", count, 0);
    chk("R9 reset chain", {hi_q, lo_q}, 0);
    clear_n = 1'b1;

    // R8 / R10: decoded-clear rings and width-3 stage
    mod_go = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      tick();
      chk("R8 mod5", m5_q, k % 5);
      chk("R8 mod11", m11_q, k % 11);
      chk("R10 width3 count", w3_q, k % 8);
      chk("R10 width3 carry", w3_c, (k % 8) == 7);
    end

    // R7 fixed sequence
    clear_n = 1'b0; tick(); clear_n = 1'b1;
    chk("R7 cleared", count, 0);
    load_n = 1'b0; load_val = 4'd12; tick(); load_n = 1'b1;
    chk("R7 preset", count, 12);
    cnt_en = 1'b1; carry_in = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R7 sequence", count, (12 + k) % 16);
      chk("R7 carry pulse", carry_out, ((12 + k) % 16) == 15);
    end
    cnt_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 inhibit hold", count, 2);
    end

    // R1..R6 sweep: every start value times every control setting
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        logic [3:0] sv, ev;
        logic c, l, e, t;
        sv = 4'(s);
        clear_n = 1'b1; load_n = 1'b0; load_val = sv;
        tick();
        c = m[3]; l = m[2]; e = m[1]; t = m[0];
        clear_n = c; load_n = l; cnt_en = e; carry_in = t; load_val = ~sv;
        #1;
        chk("R6 carry decode", carry_out, (t && s == 15));
        #2;
        chk("R1 no change between edges", count, s);
        if (!c) ev = 4'd0;
        else if (!l) ev = ~sv;
        else if (e && t) ev = sv + 4'd1;
        else ev = sv;
        tick();
        if (!c) chk("R2 clear priority", count, ev);
        else if (!l) chk("R3 load priority", count, ev);
        else if (e && t) chk("R4 increment", count, ev);
        else chk("R5 hold", count, ev);
      end
    end
    clear_n = 1'b1; load_n = 1'b1;

    // R9 chained stages versus 8-bit model
    begin
      logic [7:0] model;
      c_clear_n = 1'b0; tick();
      model = 8'd0;
      for (int k = 0; k < 4000; k++) begin
        c_clear_n = ($urandom % 16) != 0;
        c_load_n  = ($urandom % 8) != 0;
        c_en      = ($urandom % 8) != 0;
        c_chain   = ($urandom % 6) != 0;
        c_val     = 8'($urandom);
        #1;
        chk("R9 chain carry", hi_c, (c_chain && model == 8'hFF));
        if (!c_clear_n) model = 8'd0;
        else if (!c_load_n) model = c_val;
        else if (c_en && c_chain) model = model + 8'd1;
        tick();
        chk("R9 chain count", {hi_q, lo_q}, model);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule